// File: doc/BRIEF.md
# CAN Message-Buffer Interrupt Controller

This block holds the interrupt flags and masks for a CAN controller with up to 64 message buffers. Each buffer signals a finished transmit or receive with a one-cycle completion strobe. The strobe sets that buffer's flag. A buffer's interrupt line is driven when its flag and its mask bit are both set. One combined line reports whether any unmasked buffer interrupt is pending.

Five controller status events also raise interrupts in the same way, each gated by its own mask: bus off, error, transmit warning, receive warning and wake-up. When the receive FIFO is enabled, the three highest of the lowest eight buffer flags take on FIFO meanings: overflow, warning and frames available.

Software uses a simple register bus to read the flags and clear them by writing ones, and to read and write the masks and configuration. A privilege input marks each access as supervisor or user.

The bus is served by a two-state machine. `ST_IDLE` accepts a request and moves to `ST_RESP` (transition "accept"). `ST_RESP` presents the acknowledge, read data and error for one cycle, then returns to `ST_IDLE` (transition "retire"). Requests made while in `ST_RESP` are ignored.

Register word addresses:

| Address | Register |
|---|---|
| 0 | configuration: bit 0 FIFO enable, bit 1 wake-up mask |
| 1 | control: bits 3:0 masks for bus off, error, transmit warning, receive warning |
| 2 | status flags |
| 3 | mask low (buffers 0–31) |
| 4 | mask high (buffers 32–63) |
| 5 | flag low (buffers 0–31) |
| 6 | flag high (buffers 32–63) |

Top module: `can_mbirq_ctrl`

## Requirements
- R1: A pulse on `mb_done[n]` sets flag n, which reads back at address 5 (n < 32) or address 6 (n ≥ 32), at bit n mod 32.
- R2: `mb_irq[n]` is registered. It is 1 exactly when flag n and mask bit n are both 1. It changes on the same clock edge as the flag or mask that drives it.
- R3: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R4: If a completion strobe and a write-one clear hit the same flag in the same cycle, the flag stays set.
- R5: `mb_any_irq` is 1 exactly when at least one bit of `mb_irq` is 1.
- R6: With FIFO enable (address 0, bit 0) set, `mb_done[7:0]` is ignored and flag bits 4:0 read 0. Flag bit 7 is set by `fifo_ovf`, bit 6 by `fifo_warn` and bit 5 by `fifo_avail`.
- R7: Writing 0 to FIFO enable while it is set clears flag bits 7:5. After that, bits 7:0 follow `mb_done` again.
- R8: The status flags sit at address 2: bit 0 bus off, bit 1 error, bit 2 transmit warning, bit 3 receive warning, bit 4 wake-up. They are set by `ev_*` strobes and cleared by writing 1. Each interrupt output is gated by its mask: control bits 3:0 in the same order, and configuration bit 1 for wake-up.
- R9: Addresses 0 and 1 are supervisor-only. A user-mode (`bus_priv`=0) access to either one returns `bus_err`=1 with `bus_rdata`=0 and changes nothing. All other addresses accept both modes with `bus_err`=0.
- R10: Flag and mask bits at or above NBUF read 0, and writes to them are ignored.
- R11: After reset, every flag, mask, configuration bit and interrupt output is 0.
- R12: For a request accepted in `ST_IDLE`, `bus_ack` is 1 for exactly the following cycle. Read data comes from the register value before a write in the same access. A write returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_req | input | 1 | access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | register word address |
| bus_wdata | input | 32 | write data |
| bus_priv | input | 1 | 1 = supervisor, 0 = user |
| bus_ack | output | 1 | access response strobe |
| bus_rdata | output | 32 | read data, valid with `bus_ack` |
| bus_err | output | 1 | access error, valid with `bus_ack` |
| mb_done | input | NBUF | per-buffer completion strobes |
| fifo_ovf | input | 1 | FIFO overflow strobe |
| fifo_warn | input | 1 | FIFO warning strobe |
| fifo_avail | input | 1 | FIFO frames-available strobe |
| ev_busoff | input | 1 | bus-off event strobe |
| ev_err | input | 1 | error event strobe |
| ev_txwarn | input | 1 | transmit warning strobe |
| ev_rxwarn | input | 1 | receive warning strobe |
| ev_wake | input | 1 | wake-up strobe |
| mb_irq | output | NBUF | per-buffer interrupts |
| mb_any_irq | output | 1 | OR of all buffer interrupts |
| busoff_irq | output | 1 | bus-off interrupt |
| err_irq | output | 1 | error interrupt |
| txwarn_irq | output | 1 | transmit warning interrupt |
| rxwarn_irq | output | 1 | receive warning interrupt |
| wake_irq | output | 1 | wake-up interrupt |

## Verification
The bench builds the block with NBUF = 12. This has three effects:
- Every implemented buffer can be swept one at a time through set, write-zero, write-one clear and the masked case.
- The low register holds twenty unimplemented bits, and the whole high register is unimplemented, so both can be checked to read zero after all-ones writes.
- Twelve buffers is more than eight, so FIFO mode can be entered and left while ordinary buffers 8 to 11 keep working.

All five status events are swept with their masks on and off. Each supervisor-only address is accessed in both privilege modes.

// File: rtl/can_mbirq_pkg.sv
package can_mbirq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int FLAG_W = 64;
    localparam int STAT_W = 5;

    localparam logic [ADDR_W-1:0] A_CFG     = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG_LO = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAG_HI = 3'd6;

    // flag positions reused while the receive FIFO is on
    localparam int FIFO_OVF_BIT   = 7;
    localparam int FIFO_WARN_BIT  = 6;
    localparam int FIFO_AVAIL_BIT = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_st_e;

    function automatic logic sup_only(input logic [ADDR_W-1:0] a);
        return (a == A_CFG) || (a == A_CTRL);
    endfunction

endpackage

// File: rtl/can_mbirq_flagbank.sv
module can_mbirq_flagbank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] kill_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] nxt_o
);

    // kill beats set, set beats a software clear
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign nxt_o[i] = kill_i[i] ? 1'b0 : (set_i[i] | (q_o[i] & ~clr_i[i]));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o[i] <= 1'b0;
            else        q_o[i] <= nxt_o[i];
        end
    end

endmodule

// File: rtl/can_mbirq_busfsm.sv
module can_mbirq_busfsm
    import can_mbirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              priv_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic              wr_go_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    bus_st_e state_q, state_d;
    logic    take, deny;

    assign take    = (state_q == ST_IDLE) && req_i;
    assign deny    = sup_only(addr_i) && !priv_i;
    assign wr_go_o = take && wr_i && !deny;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_RESP;  // accept
            ST_RESP: state_d = ST_IDLE;             // retire
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process: capture response when a request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else if (take) begin
            err_o   <= deny;
            rdata_o <= (deny || wr_i) ? '0 : rd_word_i;
        end
    end

    assign ack_o = (state_q == ST_RESP);

endmodule

// File: rtl/can_mbirq_ctrl.sv
module can_mbirq_ctrl
    import can_mbirq_pkg::*;
#(
    parameter int NBUF = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [NBUF-1:0]   mb_done,
    input  logic              fifo_ovf,
    input  logic              fifo_warn,
    input  logic              fifo_avail,
    input  logic              ev_busoff,
    input  logic              ev_err,
    input  logic              ev_txwarn,
    input  logic              ev_rxwarn,
    input  logic              ev_wake,
    output logic [NBUF-1:0]   mb_irq,
    output logic              mb_any_irq,
    output logic              busoff_irq,
    output logic              err_irq,
    output logic              txwarn_irq,
    output logic              rxwarn_irq,
    output logic              wake_irq
);

    localparam int W    = FLAG_W;
    localparam int HALF = W / 2;

    logic [W-1:0]      impl_mask, done_pad;
    logic [W-1:0]      mb_mask_q, mb_mask_d;
    logic [W-1:0]      mb_set, mb_clr, mb_kill, mb_flag_q, mb_flag_d, mb_pend_d;
    logic [STAT_W-1:0] st_set, st_clr, st_flag_q, st_flag_d, st_mask_d;
    logic              fifo_en_q, fifo_en_d, wake_msk_q, wake_msk_d;
    logic [3:0]        ctrl_msk_q, ctrl_msk_d;
    logic              wr_go, fifo_leave;
    logic [DATA_W-1:0] rd_word;

    for (genvar i = 0; i < W; i++) begin : g_impl
        assign impl_mask[i] = (i < NBUF);
    end

    if (NBUF < W) begin : g_pad
        assign done_pad = {{(W-NBUF){1'b0}}, mb_done};
    end else begin : g_full
        assign done_pad = mb_done;
    end

    can_mbirq_busfsm u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bus_req),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .priv_i    (bus_priv),
        .rd_word_i (rd_word),
        .wr_go_o   (wr_go),
        .ack_o     (bus_ack),
        .rdata_o   (bus_rdata),
        .err_o     (bus_err)
    );

    always_comb begin
        case (bus_addr)
            A_CFG:     rd_word = {30'd0, wake_msk_q, fifo_en_q};
            A_CTRL:    rd_word = {28'd0, ctrl_msk_q};
            A_STAT:    rd_word = {27'd0, st_flag_q};
            A_MASK_LO: rd_word = mb_mask_q[HALF-1:0];
            A_MASK_HI: rd_word = mb_mask_q[W-1:HALF];
            A_FLAG_LO: rd_word = mb_flag_q[HALF-1:0];
            A_FLAG_HI: rd_word = mb_flag_q[W-1:HALF];
            default:   rd_word = '0;
        endcase
    end

    // configuration and mask next-state
    always_comb begin
        fifo_en_d  = fifo_en_q;
        wake_msk_d = wake_msk_q;
        ctrl_msk_d = ctrl_msk_q;
        mb_mask_d  = mb_mask_q;
        if (wr_go && bus_addr == A_CFG) begin
            fifo_en_d  = bus_wdata[0];
            wake_msk_d = bus_wdata[1];
        end
        if (wr_go && bus_addr == A_CTRL)    ctrl_msk_d = bus_wdata[3:0];
        if (wr_go && bus_addr == A_MASK_LO) mb_mask_d[HALF-1:0] = bus_wdata;
        if (wr_go && bus_addr == A_MASK_HI) mb_mask_d[W-1:HALF] = bus_wdata;
        mb_mask_d = mb_mask_d & impl_mask;
    end

    assign fifo_leave = fifo_en_q && !fifo_en_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en_q  <= 1'b0;
            wake_msk_q <= 1'b0;
            ctrl_msk_q <= '0;
            mb_mask_q  <= '0;
        end else begin
            fifo_en_q  <= fifo_en_d;
            wake_msk_q <= wake_msk_d;
            ctrl_msk_q <= ctrl_msk_d;
            mb_mask_q  <= mb_mask_d;
        end
    end

    // buffer flag controls
    always_comb begin
        mb_set  = done_pad;
        mb_kill = ~impl_mask;
        mb_clr  = '0;
        if (fifo_en_q) begin
            mb_set[7:0]            = '0;
            mb_set[FIFO_OVF_BIT]   = fifo_ovf;
            mb_set[FIFO_WARN_BIT]  = fifo_warn;
            mb_set[FIFO_AVAIL_BIT] = fifo_avail;
            mb_kill[4:0]           = '1;
        end
        if (fifo_leave) mb_kill[7:5] = '1;
        if (wr_go && bus_addr == A_FLAG_LO) mb_clr[HALF-1:0] = bus_wdata;
        if (wr_go && bus_addr == A_FLAG_HI) mb_clr[W-1:HALF] = bus_wdata;
    end

    can_mbirq_flagbank #(.W(W)) u_mbflags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (mb_set),
        .clr_i  (mb_clr),
        .kill_i (mb_kill),
        .q_o    (mb_flag_q),
        .nxt_o  (mb_flag_d)
    );

    assign st_set    = {ev_wake, ev_rxwarn, ev_txwarn, ev_err, ev_busoff};
    assign st_clr    = (wr_go && bus_addr == A_STAT) ? bus_wdata[STAT_W-1:0] : '0;
    assign st_mask_d = {wake_msk_d, ctrl_msk_d};

    can_mbirq_flagbank #(.W(STAT_W)) u_stflags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_set),
        .clr_i  (st_clr),
        .kill_i ({STAT_W{1'b0}}),
        .q_o    (st_flag_q),
        .nxt_o  (st_flag_d)
    );

    assign mb_pend_d = mb_flag_d & mb_mask_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_irq     <= '0;
            mb_any_irq <= 1'b0;
            busoff_irq <= 1'b0;
            err_irq    <= 1'b0;
            txwarn_irq <= 1'b0;
            rxwarn_irq <= 1'b0;
            wake_irq   <= 1'b0;
        end else begin
            mb_irq     <= mb_pend_d[NBUF-1:0];
            mb_any_irq <= |mb_pend_d;
            busoff_irq <= st_flag_d[0] & st_mask_d[0];
            err_irq    <= st_flag_d[1] & st_mask_d[1];
            txwarn_irq <= st_flag_d[2] & st_mask_d[2];
            rxwarn_irq <= st_flag_d[3] & st_mask_d[3];
            wake_irq   <= st_flag_d[4] & st_mask_d[4];
        end
    end

endmodule

// File: rtl/can_mbirq_chk.sv
module can_mbirq_chk
    import can_mbirq_pkg::*;
#(
    parameter int NBUF = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_priv,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NBUF-1:0]   mb_done,
    input logic [NBUF-1:0]   mb_irq,
    input logic              mb_any_irq,
    input logic              fifo_en,
    input logic [3:0]        ctrl_msk,
    input logic [NBUF-1:0]   flag
);

    assert_any_matches_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mb_any_irq == (mb_irq != '0));

    assert_ack_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_ack_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_ack);

    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_err) |-> (bus_rdata == '0));

    assert_user_write_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && bus_wr && !bus_priv && sup_only(bus_addr))
        |=> ($stable(fifo_en) && $stable(ctrl_msk)));

    assert_done_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && (mb_done != '0)) |=> ((flag & $past(mb_done)) == $past(mb_done)));

endmodule

bind can_mbirq_ctrl can_mbirq_chk #(.NBUF(NBUF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_priv   (bus_priv),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .mb_done    (mb_done),
    .mb_irq     (mb_irq),
    .mb_any_irq (mb_any_irq),
    .fifo_en    (fifo_en_q),
    .ctrl_msk   (ctrl_msk_q),
    .flag       (mb_flag_q[NBUF-1:0])
);

// File: tb/can_mbirq_ctrl_tb_top.sv
module can_mbirq_ctrl_tb_top;

    localparam int NB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ack, bus_err;
    logic [31:0]   bus_rdata;
    logic [NB-1:0] mb_done = '0;
    logic          fifo_ovf = 1'b0, fifo_warn = 1'b0, fifo_avail = 1'b0;
    logic [4:0]    ev = '0;
    logic [NB-1:0] mb_irq;
    logic          mb_any_irq, busoff_irq, err_irq, txwarn_irq, rxwarn_irq, wake_irq;
    logic [4:0]    st_irq;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    assign st_irq = {wake_irq, rxwarn_irq, txwarn_irq, err_irq, busoff_irq};

    can_mbirq_ctrl #(.NBUF(NB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .mb_done(mb_done), .fifo_ovf(fifo_ovf), .fifo_warn(fifo_warn),
        .fifo_avail(fifo_avail),
        .ev_busoff(ev[0]), .ev_err(ev[1]), .ev_txwarn(ev[2]),
        .ev_rxwarn(ev[3]), .ev_wake(ev[4]),
        .mb_irq(mb_irq), .mb_any_irq(mb_any_irq),
        .busoff_irq(busoff_irq), .err_irq(err_irq), .txwarn_irq(txwarn_irq),
        .rxwarn_irq(rxwarn_irq), .wake_irq(wake_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [2:0] addr, input logic [31:0] data,
                          input logic priv, output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data; bus_priv = priv;
        @(negedge clk);
        bus_req = 1'b0;
        check("R12 ack", {63'd0, bus_ack}, 64'd1);
        rd = bus_rdata;
        er = bus_err;
        @(negedge clk);
        check("R12 ack drop", {63'd0, bus_ack}, 64'd0);
    endtask

    task automatic wr_sup(input logic [2:0] addr, input logic [31:0] data);
        logic [31:0] rd; logic er;
        access(1'b1, addr, data, 1'b1, rd, er);
        check("R12 write rdata", {32'd0, rd}, 64'd0);
    endtask

    task automatic rd_expect(input string req, input logic [2:0] addr, input logic [31:0] exp);
        logic [31:0] rd; logic er;
        access(1'b0, addr, 32'd0, 1'b1, rd, er);
        check(req, {32'd0, rd}, {32'd0, exp});
    endtask

    task automatic pulse_buf(input int idx);
        @(negedge clk); mb_done[idx] = 1'b1;
        @(negedge clk); mb_done = '0;
    endtask

    task automatic pulse_ev(input int idx);
        @(negedge clk); ev[idx] = 1'b1;
        @(negedge clk); ev = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 7; a++) rd_expect("R11 reset reg", a[2:0], 32'd0);
        check("R11 irq", {51'd0, mb_any_irq, mb_irq}, 64'd0);
        check("R11 st irq", {59'd0, st_irq}, 64'd0);

        // R10 unimplemented mask bits
        wr_sup(3'd3, 32'hFFFF_FFFF);
        wr_sup(3'd4, 32'hFFFF_FFFF);
        rd_expect("R10 mask lo", 3'd3, (32'd1 << NB) - 1);
        rd_expect("R10 mask hi", 3'd4, 32'd0);

        // R1 R2 R3 R5 sweep over every buffer
        for (int i = 0; i < NB; i++) begin
            pulse_buf(i);
            check("R2 line", {52'd0, mb_irq}, 64'd1 << i);
            check("R5 any", {63'd0, mb_any_irq}, 64'd1);
            rd_expect("R1 flag", 3'd5, 32'd1 << i);
            wr_sup(3'd5, 32'd0);
            rd_expect("R3 write zero", 3'd5, 32'd1 << i);
            wr_sup(3'd5, 32'd1 << i);
            rd_expect("R3 clear", 3'd5, 32'd0);
            check("R2 line cleared", {51'd0, mb_any_irq, mb_irq}, 64'd0);
        end
        wr_sup(3'd6, 32'hFFFF_FFFF);
        rd_expect("R10 flag hi", 3'd6, 32'd0);

        // R2 masked buffer
        wr_sup(3'd3, 32'hFFFF_FFFE);
        pulse_buf(0);
        check("R2 masked", {51'd0, mb_any_irq, mb_irq}, 64'd0);
        rd_expect("R2 masked flag", 3'd5, 32'd1);
        wr_sup(3'd3, 32'hFFFF_FFFF);
        check("R2 mask on", {52'd0, mb_irq}, 64'd1);
        wr_sup(3'd5, 32'd1);

        // R4 set beats clear
        pulse_buf(3);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'd8; bus_priv = 1'b1;
        mb_done[3] = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; mb_done = '0;
        @(negedge clk);
        rd_expect("R4 set wins", 3'd5, 32'd8);
        wr_sup(3'd5, 32'd8);

        // R6 FIFO mode
        wr_sup(3'd0, 32'd1);
        pulse_buf(6);
        pulse_buf(2);
        rd_expect("R6 done ignored", 3'd5, 32'd0);
        @(negedge clk); fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0;
        rd_expect("R6 overflow", 3'd5, 32'h80);
        @(negedge clk); fifo_warn = 1'b1; @(negedge clk); fifo_warn = 1'b0;
        @(negedge clk); fifo_avail = 1'b1; @(negedge clk); fifo_avail = 1'b0;
        rd_expect("R6 three flags", 3'd5, 32'hE0);
        check("R6 lines", {52'd0, mb_irq}, 64'hE0);
        pulse_buf(9);
        rd_expect("R6 high buffer", 3'd5, 32'h2E0);
        wr_sup(3'd5, 32'h240);
        rd_expect("R6 clear warn", 3'd5, 32'hA0);

        // R7 leave FIFO mode
        wr_sup(3'd0, 32'd0);
        rd_expect("R7 cleared", 3'd5, 32'd0);
        check("R7 lines", {51'd0, mb_any_irq, mb_irq}, 64'd0);
        pulse_buf(6);
        rd_expect("R7 normal again", 3'd5, 32'h40);
        wr_sup(3'd5, 32'h40);

        // R8 status events
        wr_sup(3'd1, 32'hF);
        wr_sup(3'd0, 32'd2);
        for (int k = 0; k < 5; k++) begin
            pulse_ev(k);
            check("R8 status line", {59'd0, st_irq}, 64'd1 << k);
            rd_expect("R8 status flag", 3'd2, 32'd1 << k);
            wr_sup(3'd2, 32'd1 << k);
            rd_expect("R8 status clear", 3'd2, 32'd0);
        end
        wr_sup(3'd1, 32'd0);
        wr_sup(3'd0, 32'd0);
        for (int k = 0; k < 5; k++) begin
            pulse_ev(k);
            check("R8 status masked", {59'd0, st_irq}, 64'd0);
            rd_expect("R8 masked flag", 3'd2, 32'd1 << k);
            wr_sup(3'd2, 32'h1F);
        end

        // R9 privilege
        wr_sup(3'd0, 32'd2);
        wr_sup(3'd1, 32'd5);
        access(1'b1, 3'd0, 32'd1, 1'b0, rd, er);
        check("R9 user write cfg err", {63'd0, er}, 64'd1);
        rd_expect("R9 cfg unchanged", 3'd0, 32'd2);
        access(1'b1, 3'd1, 32'hF, 1'b0, rd, er);
        check("R9 user write ctrl err", {63'd0, er}, 64'd1);
        rd_expect("R9 ctrl unchanged", 3'd1, 32'd5);
        access(1'b0, 3'd1, 32'd0, 1'b0, rd, er);
        check("R9 user read err", {63'd0, er}, 64'd1);
        check("R9 user read data", {32'd0, rd}, 64'd0);
        access(1'b0, 3'd3, 32'd0, 1'b0, rd, er);
        check("R9 user mask ok", {63'd0, er}, 64'd0);
        check("R9 user mask data", {32'd0, rd}, 64'hFFF);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule